// File: doc/BRIEF.md
# Palette-Based Gray-Level Column Modulator

This block turns one stored display line of 2-bit pixel codes into a per-column drive-level selection for a liquid-crystal column driver. Each code is not used as a brightness directly. It indexes a four-entry palette, and each palette entry holds one of 25 gray levels (0 to 24). A level is rendered over time in two ways at once. Some frames of a five-frame cycle are driven fully on. In one further frame, only some of the five modulation sub-slots inside the line period are driven on.

The line data is accepted on every pulse of `line_strobe` and never back-pressured: the strobe works as an always-accepted valid, so upstream simply presents a full line and pulses the strobe. The palette, the frame marker, the modulation tick and the display-off input are plain control pins, all sampled on the rising clock edge. Each column output is a 2-bit code that picks the off level, the on level or the blanking level.

Top module: `gray_column_modulator`

## Requirements
- R1: After reset, palette entries for codes 0, 1, 2 and 3 hold levels 0, 8, 16 and 24. The frame phase and sub-slot counters are 0, the stored line is all code 0, and every column output is 2'b00.
- R2: `line_data` is copied into the stored line only in a cycle with `line_strobe` high. Changes of `line_data` at any other time leave the outputs unchanged. Column c uses bits [2c+1:2c].
- R3: A cycle with `pal_we` high writes `pal_wdata` into the palette entry selected by `pal_addr`. A value above 24 is stored as 24.
- R4: The frame phase counter advances by one on each cycle with `frame_mark` high. It wraps from 4 to 0.
- R5: The sub-slot counter clears to 0 on `line_strobe`, and the strobe wins over a simultaneous `mod_tick`. Otherwise it advances by one on each `mod_tick` and wraps from 4 to 0.
- R6: For a level n below 24, write n = 5f + p with 0 ≤ p ≤ 4. A column is on when the frame phase is below f. It is also on when the phase equals f and the sub-slot is below p. In every other case it is off.
- R7: Level 0 is off and level 24 is on in every frame phase and every sub-slot.
- R8: While `disp_off` is high, every column output is 2'b01, whatever the pixel data or the palette.
- R9: The output code is 2'b00 for off (V0), 2'b10 for on (V2) and 2'b01 for blanking (V1). The code 2'b11 never appears.
- R10: The outputs are registered. A change of `disp_off` shows one clock edge after it is sampled. A strobe, a palette write, a frame marker or a tick shows two clock edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_strobe | input | 1 | Captures `line_data` and clears the sub-slot counter |
| line_data | input | 2*NUM_COLS | Packed 2-bit pixel codes, column 0 in the low bits |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | 2 | Palette entry (pixel code) to write |
| pal_wdata | input | 5 | Gray level to write, clamped to 24 |
| frame_mark | input | 1 | One-cycle frame start marker |
| mod_tick | input | 1 | One-cycle modulation sub-slot tick |
| disp_off | input | 1 | Forces every column to the blanking code |
| drive_sel | output | 2*NUM_COLS | Per-column drive code, column 0 in the low bits |

## Verification
`disp_off` is registered straight into the output flops, so its effect is due one edge after it is sampled. The stored line, the palette and the two counters each add one register ahead of the output flops, so their effects are due two edges after they are sampled. The bench drives inputs on falling edges and keeps every pulse one cycle long. It then samples at the falling edge after the expected number of rising edges. The latency checks for R10 also sample one edge early and expect the old output there.

// File: rtl/gcm_pkg.sv
package gcm_pkg;

  // Column drive codes
  localparam logic [1:0] DRV_OFF   = 2'b00;  // V0
  localparam logic [1:0] DRV_BLANK = 2'b01;  // V1
  localparam logic [1:0] DRV_ON    = 2'b10;  // V2

  // Duty weight of a gray level: the top level is promoted to a full cycle
  function automatic int level_weight(input int lvl, input int max_level,
                                      input int frames, input int slots);
    if (lvl >= max_level) return frames * slots;
    return lvl;
  endfunction

endpackage

// File: rtl/gcm_palette.sv
module gcm_palette #(
  parameter int CODE_W    = 2,
  parameter int LVL_W     = 5,
  parameter int MAX_LEVEL = 24,
  localparam int NUM_CODES = 1 << CODE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [CODE_W-1:0]           addr,
  input  logic [LVL_W-1:0]            wdata,
  output logic [NUM_CODES*LVL_W-1:0]  levels
);

  logic [LVL_W-1:0] entry [NUM_CODES];
  logic [LVL_W-1:0] wclamp;

  always_comb begin
    if (int'(wdata) > MAX_LEVEL) wclamp = LVL_W'(MAX_LEVEL);
    else                         wclamp = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_CODES; k++)
        entry[k] <= LVL_W'((k * MAX_LEVEL) / (NUM_CODES - 1));
    end else if (we) begin
      entry[addr] <= wclamp;
    end
  end

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_flat
    assign levels[k*LVL_W +: LVL_W] = entry[k];
  end

  AST_PAL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(wdata) > MAX_LEVEL) |=> (int'(entry[$past(addr)]) == MAX_LEVEL)); // R3

  AST_PAL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(wdata) <= MAX_LEVEL) |=> (entry[$past(addr)] == $past(wdata))); // R3

endmodule

// File: rtl/gcm_phase_gen.sv
module gcm_phase_gen #(
  parameter int FRAMES = 5,
  parameter int SLOTS  = 5,
  localparam int PH_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int SL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_mark,
  input  logic            mod_tick,
  input  logic            line_strobe,
  output logic [PH_W-1:0] phase,
  output logic [SL_W-1:0] slot
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (frame_mark) begin
      if (phase == PH_W'(FRAMES - 1)) phase <= '0;
      else                            phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot <= '0;
    end else if (line_strobe) begin
      slot <= '0;
    end else if (mod_tick) begin
      if (slot == SL_W'(SLOTS - 1)) slot <= '0;
      else                          slot <= slot + 1'b1;
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase) < FRAMES); // R4

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_mark && phase == PH_W'(FRAMES - 1)) |=> (phase == '0)); // R4

  AST_SLOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    line_strobe |=> (slot == '0)); // R5

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_strobe && mod_tick && int'(slot) < SLOTS - 1) |=> (slot == $past(slot) + 1'b1)); // R5

endmodule

// File: rtl/gcm_level_eval.sv
module gcm_level_eval #(
  parameter int CODE_W    = 2,
  parameter int LVL_W     = 5,
  parameter int FRAMES    = 5,
  parameter int SLOTS     = 5,
  parameter int MAX_LEVEL = 24,
  localparam int NUM_CODES = 1 << CODE_W,
  localparam int PH_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int SL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [NUM_CODES*LVL_W-1:0] levels,
  input  logic [PH_W-1:0]            phase,
  input  logic [SL_W-1:0]            slot,
  output logic [NUM_CODES-1:0]       code_on
);

  // One evaluation per palette entry; columns only select among them
  for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
    int weight;
    int full_frames;
    int part_slots;
    always_comb begin
      weight      = gcm_pkg::level_weight(int'(levels[k*LVL_W +: LVL_W]),
                                          MAX_LEVEL, FRAMES, SLOTS);
      full_frames = weight / SLOTS;
      part_slots  = weight % SLOTS;
      code_on[k]  = (int'(phase) < full_frames) ||
                    ((int'(phase) == full_frames) && (int'(slot) < part_slots));
    end
  end

endmodule

// File: rtl/gcm_column_drive.sv
module gcm_column_drive #(
  parameter int NUM_COLS = 240,
  parameter int CODE_W   = 2,
  localparam int NUM_CODES = 1 << CODE_W,
  localparam int LINE_W    = NUM_COLS * CODE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_strobe,
  input  logic [LINE_W-1:0]     line_data,
  input  logic [NUM_CODES-1:0]  code_on,
  input  logic                  disp_off,
  output logic [2*NUM_COLS-1:0] drive_sel
);
  import gcm_pkg::*;

  localparam logic [2*NUM_COLS-1:0] ALL_BLANK = {NUM_COLS{DRV_BLANK}};

  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           line_q <= '0;
    else if (line_strobe) line_q <= line_data;
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [CODE_W-1:0] code;
    assign code = line_q[c*CODE_W +: CODE_W];
    always_ff @(posedge clk) begin
      if (!rst_n)           drive_sel[2*c +: 2] <= DRV_OFF;
      else if (disp_off)    drive_sel[2*c +: 2] <= DRV_BLANK;
      else if (code_on[code]) drive_sel[2*c +: 2] <= DRV_ON;
      else                  drive_sel[2*c +: 2] <= DRV_OFF;
    end
  end

  AST_BLANK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |=> (drive_sel == ALL_BLANK)); // R8

  AST_NO_BLANK_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_off |=> (drive_sel[1:0] != DRV_BLANK)); // R9

  AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    drive_sel[2*NUM_COLS-1 -: 2] != 2'b11); // R9

endmodule

// File: rtl/gray_column_modulator.sv
module gray_column_modulator #(
  parameter int NUM_COLS  = 240,
  parameter int FRAMES    = 5,
  parameter int SLOTS     = 5,
  parameter int LVL_W     = 5,
  localparam int CODE_W    = 2,
  localparam int NUM_CODES = 1 << CODE_W,
  localparam int MAX_LEVEL = FRAMES * SLOTS - 1,
  localparam int PH_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int SL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     line_strobe,
  input  logic [CODE_W*NUM_COLS-1:0] line_data,
  input  logic                     pal_we,
  input  logic [CODE_W-1:0]        pal_addr,
  input  logic [LVL_W-1:0]         pal_wdata,
  input  logic                     frame_mark,
  input  logic                     mod_tick,
  input  logic                     disp_off,
  output logic [2*NUM_COLS-1:0]    drive_sel
);

  logic [NUM_CODES*LVL_W-1:0] levels;
  logic [PH_W-1:0]            phase;
  logic [SL_W-1:0]            slot;
  logic [NUM_CODES-1:0]       code_on;

  gcm_palette #(.CODE_W(CODE_W), .LVL_W(LVL_W), .MAX_LEVEL(MAX_LEVEL)) u_palette (
    .clk(clk), .rst_n(rst_n), .we(pal_we), .addr(pal_addr),
    .wdata(pal_wdata), .levels(levels)
  );

  gcm_phase_gen #(.FRAMES(FRAMES), .SLOTS(SLOTS)) u_phase (
    .clk(clk), .rst_n(rst_n), .frame_mark(frame_mark), .mod_tick(mod_tick),
    .line_strobe(line_strobe), .phase(phase), .slot(slot)
  );

  gcm_level_eval #(.CODE_W(CODE_W), .LVL_W(LVL_W), .FRAMES(FRAMES),
                   .SLOTS(SLOTS), .MAX_LEVEL(MAX_LEVEL)) u_eval (
    .levels(levels), .phase(phase), .slot(slot), .code_on(code_on)
  );

  gcm_column_drive #(.NUM_COLS(NUM_COLS), .CODE_W(CODE_W)) u_cols (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .line_data(line_data),
    .code_on(code_on), .disp_off(disp_off), .drive_sel(drive_sel)
  );

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_extreme_chk
    AST_LEVEL_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (levels[k*LVL_W +: LVL_W] == '0) |-> !code_on[k]); // R7
    AST_LEVEL_TOP_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(levels[k*LVL_W +: LVL_W]) == MAX_LEVEL) |-> code_on[k]); // R7
  end

endmodule

// File: tb/gray_column_modulator_tb.sv
module gray_column_modulator_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam logic [2*NC-1:0] ALL_OFF   = {NC{2'b00}};
  localparam logic [2*NC-1:0] ALL_ON    = {NC{2'b10}};
  localparam logic [2*NC-1:0] ALL_BLANK = {NC{2'b01}};
  localparam logic [2*NC-1:0] CODES_ONE = {NC{2'b01}};

  // {level[4:0], phase[2:0], slot[2:0], expected_on}
  localparam int NVEC = 19;
  localparam logic [11:0] VEC [NVEC] = '{
    {5'd0,  3'd0, 3'd0, 1'b0}, {5'd24, 3'd4, 3'd4, 1'b1},
    {5'd7,  3'd0, 3'd4, 1'b1}, {5'd7,  3'd1, 3'd1, 1'b1},
    {5'd7,  3'd1, 3'd2, 1'b0}, {5'd7,  3'd2, 3'd0, 1'b0},
    {5'd12, 3'd1, 3'd3, 1'b1}, {5'd12, 3'd2, 3'd1, 1'b1},
    {5'd12, 3'd2, 3'd3, 1'b0}, {5'd12, 3'd3, 3'd0, 1'b0},
    {5'd23, 3'd4, 3'd2, 1'b1}, {5'd23, 3'd4, 3'd3, 1'b0},
    {5'd5,  3'd0, 3'd4, 1'b1}, {5'd5,  3'd1, 3'd0, 1'b0},
    {5'd31, 3'd4, 3'd4, 1'b1}, {5'd1,  3'd0, 3'd0, 1'b1},
    {5'd1,  3'd0, 3'd1, 1'b0}, {5'd24, 3'd2, 3'd0, 1'b1},
    {5'd0,  3'd3, 3'd4, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic line_strobe, pal_we, frame_mark, mod_tick, disp_off;
  logic [2*NC-1:0] line_data;
  logic [1:0] pal_addr;
  logic [4:0] pal_wdata;
  logic [2*NC-1:0] drive_sel;

  int nvec = 0;
  int nerr = 0;
  int ph = 0;
  int sl = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gray_column_modulator #(.NUM_COLS(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .line_data(line_data),
    .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
    .frame_mark(frame_mark), .mod_tick(mod_tick), .disp_off(disp_off),
    .drive_sel(drive_sel)
  );

  // Behaviour from R6/R7: on-state of a level at a phase and sub-slot
  function automatic bit model_on(input int lvl, input int p, input int s);
    int w;
    if (lvl > 24) lvl = 24;
    w = (lvl == 24) ? 25 : lvl;
    return (p < w / 5) || (p == w / 5 && s < w % 5);
  endfunction

  task automatic check_cols(input logic [2*NC-1:0] exp, input string tag);
    nvec++;
    if (drive_sel !== exp) begin
      nerr++;
      $display("FAIL %s: drive_sel=%h expected %h", tag, drive_sel, exp);
    end
  endtask

  task automatic pulse_mark();
    @(negedge clk) frame_mark = 1'b1;
    @(negedge clk) frame_mark = 1'b0;
    ph = (ph + 1) % 5;
  endtask

  task automatic pulse_tick();
    @(negedge clk) mod_tick = 1'b1;
    @(negedge clk) mod_tick = 1'b0;
    sl = (sl + 1) % 5;
  endtask

  task automatic strobe_line(input logic [2*NC-1:0] d);
    @(negedge clk) begin line_data = d; line_strobe = 1'b1; end
    @(negedge clk) line_strobe = 1'b0;
    sl = 0;
  endtask

  task automatic write_pal(input logic [1:0] a, input logic [4:0] v);
    @(negedge clk) begin pal_addr = a; pal_wdata = v; pal_we = 1'b1; end
    @(negedge clk) pal_we = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [2*NC-1:0] exp;
    rst_n = 1'b0; line_strobe = 1'b0; pal_we = 1'b0; frame_mark = 1'b0;
    mod_tick = 1'b0; disp_off = 1'b0; line_data = '0; pal_addr = '0; pal_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_cols(ALL_OFF, "R1 reset outputs");

    // R1: default palette 0,8,16,24 on codes 0..3 at phase 0 slot 0
    strobe_line({NC/4{2'b11, 2'b10, 2'b01, 2'b00}});
    settle();
    for (int c = 0; c < NC; c++)
      exp[2*c +: 2] = model_on((c % 4) * 8, 0, 0) ? 2'b10 : 2'b00;
    check_cols(exp, "R1 default palette");

    // R6 mixed columns at phase 2 slot 3 with default palette
    pulse_mark(); pulse_mark();
    repeat (3) pulse_tick();
    settle();
    for (int c = 0; c < NC; c++)
      exp[2*c +: 2] = model_on((c % 4) * 8, ph, sl) ? 2'b10 : 2'b00;
    check_cols(exp, "R6 mixed codes");

    // Table walk: R3 R4 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      int tph;
      int tsl;
      write_pal(2'd1, VEC[i][11:7]);
      strobe_line(CODES_ONE);
      tph = int'(VEC[i][6:4]);
      tsl = int'(VEC[i][3:1]);
      while (ph != tph) pulse_mark();
      repeat (tsl) pulse_tick();
      settle();
      check_cols(VEC[i][0] ? ALL_ON : ALL_OFF, "R6/R7 table (R3 clamp, R4 wrap)");
    end

    // R5: sub-slot wraps 4 -> 0
    write_pal(2'd1, 5'd1);
    while (ph != 0) pulse_mark();
    strobe_line(CODES_ONE);
    repeat (5) pulse_tick();
    settle();
    check_cols(ALL_ON, "R5 slot wrap");

    // R5: strobe wins over simultaneous tick
    repeat (2) pulse_tick();
    settle();
    check_cols(ALL_OFF, "R5 slot 2 level 1");
    @(negedge clk) begin line_data = CODES_ONE; line_strobe = 1'b1; mod_tick = 1'b1; end
    @(negedge clk) begin line_strobe = 1'b0; mod_tick = 1'b0; end
    sl = 0;
    settle();
    check_cols(ALL_ON, "R5 strobe priority");

    // R2: line_data without strobe is ignored
    @(negedge clk) line_data = '0;
    settle();
    check_cols(ALL_ON, "R2 no strobe");
    // R10: strobe result not yet visible one edge later, visible after two
    @(negedge clk) line_strobe = 1'b1;
    @(negedge clk) line_strobe = 1'b0;
    check_cols(ALL_ON, "R10 strobe one edge");
    @(negedge clk);
    check_cols(ALL_OFF, "R2 strobe captures / R10 two edges");

    // R8 / R10: display off after one edge, release restores data
    @(negedge clk) disp_off = 1'b1;
    @(negedge clk);
    check_cols(ALL_BLANK, "R8 display off / R10 one edge");
    write_pal(2'd0, 5'd24);
    settle();
    check_cols(ALL_BLANK, "R8 held over palette change");
    @(negedge clk) disp_off = 1'b0;
    @(negedge clk);
    check_cols(ALL_ON, "R9 release to on code");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule